// File: doc/BRIEF.md
# Predicate Compare Writeback Unit

This block takes the result of one compare or one bit test per cycle and turns it into writes of two target bits in a 64-entry, one-bit predicate file. A compare-type selector picks one of five write behaviours. Each behaviour treats the qualifying predicate and the relation result in its own way. The block either compares two 64-bit operands with one of eight relations or tests one bit of the first operand. Each source operand carries a deferred-exception flag, and a set flag on either operand forces the relation to false.

Two combinational read ports let the surrounding pipeline fetch a qualifying predicate and a branch predicate. A third, internal read fetches the qualifying predicate of the operation being applied. Entry 0 is hard-wired true. Writes land at the clock edge, so a read in the same cycle returns the previous value.

Top module: `pred_cmp_wb`

## Requirements
- R1: After a synchronous reset, every entry 1..63 reads 0 and entry 0 reads 1.
- R2: Entry 0 always reads 1 on both read ports, and writes that name index 0 are dropped.
- R3: Kind code 0 (normal): when the qualifying predicate is 1, target one gets the relation and target two gets its inverse. When it is 0, neither target changes.
- R4: Kind code 1 (unconditional): both targets are always written, target one with qp AND relation and target two with qp AND NOT relation.
- R5: Kind code 2 (and-type): when qp is 1 and the relation is false, both targets are cleared. Otherwise nothing is written.
- R6: Kind code 3 (or-type): when qp is 1 and the relation is true, both targets are set. Otherwise nothing is written.
- R7: Kind code 4 (or-andcm): when qp is 1 and the relation is true, target one is set and target two is cleared. Otherwise nothing is written.
- R8: With rel_sel = 0, rel_fn selects the relation between src_a and src_b: 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal.
- R9: With rel_sel = 1, the relation is bit bit_pos of src_a, where bit 0 is the least significant bit.
- R10: If nat_a or nat_b is 1, the relation is treated as false before the write rules are applied.
- R11: When both targets name the same entry and both are written, the value for target one is stored.
- R12: A read returns the value held before the clock edge that applies a write. The new value is readable right after that edge.
- R13: With op_valid low, or with a kind code of 5 to 7, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Apply an operation this cycle |
| cmp_kind | input | 3 | Write behaviour code |
| rel_sel | input | 1 | 0 selects an operand compare, 1 selects a bit test |
| rel_fn | input | 3 | Relation code for operand compare |
| src_a | input | 64 | First operand, and the tested word for a bit test |
| src_b | input | 64 | Second operand |
| nat_a | input | 1 | Deferred-exception flag of src_a |
| nat_b | input | 1 | Deferred-exception flag of src_b |
| bit_pos | input | 6 | Bit index for a bit test |
| qp_idx | input | 6 | Qualifying predicate index |
| t1_idx | input | 6 | First target index |
| t2_idx | input | 6 | Second target index |
| rd_qp_idx | input | 6 | Read port A index |
| rd_br_idx | input | 6 | Read port B index |
| rd_qp_val | output | 1 | Read port A data |
| rd_br_val | output | 1 | Read port B data |

## Verification
Directed operations run each relation code on an operand pair where the signed and unsigned orderings disagree, so a swapped signedness shows up. Each kind is driven with the qualifying predicate both true and false and with the relation both true and false. Each target is primed to the value opposite to the one a write would give, so a missing or spurious write is visible. Targets that alias each other and targets at index 0 separate the write-priority and hard-wired-entry rules. A long pseudo-random run mixes all kind codes, including the unused ones, with deferred-exception flags and equal operands, and compares both targets against the bench model before and after every edge.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [2:0] {
    CK_NORM    = 3'd0,
    CK_UNC     = 3'd1,
    CK_AND     = 3'd2,
    CK_OR      = 3'd3,
    CK_ORANDCM = 3'd4
  } cmp_kind_e;

  typedef enum logic [2:0] {
    RF_EQ  = 3'd0,
    RF_NE  = 3'd1,
    RF_LT  = 3'd2,
    RF_LE  = 3'd3,
    RF_GT  = 3'd4,
    RF_GE  = 3'd5,
    RF_LTU = 3'd6,
    RF_GEU = 3'd7
  } rel_fn_e;

  typedef struct packed {
    logic en1;
    logic val1;
    logic en2;
    logic val2;
  } tgt_wr_t;
endpackage

// File: rtl/pcw_relation.sv
module pcw_relation #(
  parameter int DW = 64,
  localparam int BW = $clog2(DW)
) (
  input  logic          rel_sel,
  input  logic [2:0]    rel_fn,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          nat_a,
  input  logic          nat_b,
  input  logic [BW-1:0] bit_pos,
  output logic          rel_o
);
  import pcw_pkg::*;

  logic cmp_res;
  logic raw;

  always_comb begin
    unique case (rel_fn_e'(rel_fn))
      RF_EQ:   cmp_res = (src_a == src_b);
      RF_NE:   cmp_res = (src_a != src_b);
      RF_LT:   cmp_res = ($signed(src_a) <  $signed(src_b));
      RF_LE:   cmp_res = ($signed(src_a) <= $signed(src_b));
      RF_GT:   cmp_res = ($signed(src_a) >  $signed(src_b));
      RF_GE:   cmp_res = ($signed(src_a) >= $signed(src_b));
      RF_LTU:  cmp_res = (src_a <  src_b);
      RF_GEU:  cmp_res = (src_a >= src_b);
      default: cmp_res = 1'b0;
    endcase
  end

  assign raw   = rel_sel ? src_a[bit_pos] : cmp_res;
  // a deferred exception on either source turns the result false
  assign rel_o = raw & ~(nat_a | nat_b);
endmodule

// File: rtl/pcw_write_ctl.sv
module pcw_write_ctl (
  input  logic             valid,
  input  logic [2:0]       kind,
  input  logic             qp,
  input  logic             rel,
  output pcw_pkg::tgt_wr_t wr
);
  import pcw_pkg::*;

  always_comb begin
    wr = '0;
    if (valid) begin
      unique case (cmp_kind_e'(kind))
        CK_NORM: begin
          wr.en1  = qp;
          wr.en2  = qp;
          wr.val1 = rel;
          wr.val2 = ~rel;
        end
        CK_UNC: begin
          wr.en1  = 1'b1;
          wr.en2  = 1'b1;
          wr.val1 = qp & rel;
          wr.val2 = qp & ~rel;
        end
        CK_AND: begin
          wr.en1  = qp & ~rel;
          wr.en2  = qp & ~rel;
          wr.val1 = 1'b0;
          wr.val2 = 1'b0;
        end
        CK_OR: begin
          wr.en1  = qp & rel;
          wr.en2  = qp & rel;
          wr.val1 = 1'b1;
          wr.val2 = 1'b1;
        end
        CK_ORANDCM: begin
          wr.en1  = qp & rel;
          wr.en2  = qp & rel;
          wr.val1 = 1'b1;
          wr.val2 = 1'b0;
        end
        default: wr = '0;
      endcase
    end
  end
endmodule

// File: rtl/pcw_pred_file.sv
module pcw_pred_file #(
  parameter int NE  = 64,
  parameter int NRD = 3,
  localparam int AW = $clog2(NE)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we1,
  input  logic [AW-1:0]          wa1,
  input  logic                   wd1,
  input  logic                   we2,
  input  logic [AW-1:0]          wa2,
  input  logic                   wd2,
  input  logic [NRD-1:0][AW-1:0] ra,
  output logic [NRD-1:0]         rd,
  output logic [NE-1:0]          snap_o
);
  // entry 0 has no storage: it is a constant true
  logic [NE-1:1] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else begin
      if (we2 && wa2 != '0) bits[wa2] <= wd2;
      // issued last so that target one wins an aliased pair
      if (we1 && wa1 != '0) bits[wa1] <= wd1;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (ra[g] == '0) ? 1'b1 : bits[ra[g]];
  end

  assign snap_o = {bits, 1'b1};
endmodule

// File: rtl/pred_cmp_wb.sv
module pred_cmp_wb #(
  parameter int NPRED = 64,
  parameter int DW    = 64,
  localparam int AW   = $clog2(NPRED),
  localparam int BW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    cmp_kind,
  input  logic          rel_sel,
  input  logic [2:0]    rel_fn,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          nat_a,
  input  logic          nat_b,
  input  logic [BW-1:0] bit_pos,
  input  logic [AW-1:0] qp_idx,
  input  logic [AW-1:0] t1_idx,
  input  logic [AW-1:0] t2_idx,
  input  logic [AW-1:0] rd_qp_idx,
  input  logic [AW-1:0] rd_br_idx,
  output logic          rd_qp_val,
  output logic          rd_br_val
);
  import pcw_pkg::*;

  localparam int NRD = 3;

  logic                   rel_final;
  logic                   qp_val;
  tgt_wr_t                wr;
  logic [NRD-1:0][AW-1:0] ra;
  logic [NRD-1:0]         rd;
  logic [NPRED-1:0]       pred_snap;

  pcw_relation #(.DW(DW)) u_rel (
    .rel_sel (rel_sel),
    .rel_fn  (rel_fn),
    .src_a   (src_a),
    .src_b   (src_b),
    .nat_a   (nat_a),
    .nat_b   (nat_b),
    .bit_pos (bit_pos),
    .rel_o   (rel_final)
  );

  pcw_write_ctl u_ctl (
    .valid (op_valid),
    .kind  (cmp_kind),
    .qp    (qp_val),
    .rel   (rel_final),
    .wr    (wr)
  );

  assign ra[0] = rd_qp_idx;
  assign ra[1] = rd_br_idx;
  assign ra[2] = qp_idx;

  pcw_pred_file #(.NE(NPRED), .NRD(NRD)) u_file (
    .clk    (clk),
    .rst    (rst),
    .we1    (wr.en1),
    .wa1    (t1_idx),
    .wd1    (wr.val1),
    .we2    (wr.en2),
    .wa2    (t2_idx),
    .wd2    (wr.val2),
    .ra     (ra),
    .rd     (rd),
    .snap_o (pred_snap)
  );

  assign rd_qp_val = rd[0];
  assign rd_br_val = rd[1];
  assign qp_val    = rd[2];
endmodule

// File: rtl/pred_cmp_wb_chk.sv
module pred_cmp_wb_chk #(
  parameter int NPRED = 64,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       cmp_kind,
  input logic [AW-1:0]    t1_idx,
  input logic [AW-1:0]    rd_br_idx,
  input logic             rd_br_val,
  input logic             qp_val,
  input logic             rel_final,
  input logic             nat_a,
  input logic             nat_b,
  input logic [NPRED-1:0] pred_snap
);
  // R2
  p0_true_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_br_idx == '0) |-> rd_br_val);

  // R4
  unc_first_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_kind == 3'd1 && t1_idx != '0)
      |=> pred_snap[$past(t1_idx)] == $past(qp_val & rel_final));

  // R5
  and_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_kind == 3'd2 && rel_final) |=> $stable(pred_snap));

  // R6
  or_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_kind == 3'd3 && !qp_val) |=> $stable(pred_snap));

  // R10
  nat_false_chk: assert property (@(posedge clk) disable iff (rst)
    (nat_a || nat_b) |-> !rel_final);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || cmp_kind > 3'd4) |=> $stable(pred_snap));
endmodule

bind pred_cmp_wb pred_cmp_wb_chk #(.NPRED(NPRED), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .cmp_kind  (cmp_kind),
  .t1_idx    (t1_idx),
  .rd_br_idx (rd_br_idx),
  .rd_br_val (rd_br_val),
  .qp_val    (qp_val),
  .rel_final (rel_final),
  .nat_a     (nat_a),
  .nat_b     (nat_b),
  .pred_snap (pred_snap)
);

// File: tb/pred_cmp_wb_tb.sv
module pred_cmp_wb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  cmp_kind;
  logic        rel_sel;
  logic [2:0]  rel_fn;
  logic [63:0] src_a, src_b;
  logic        nat_a, nat_b;
  logic [5:0]  bit_pos, qp_idx, t1_idx, t2_idx, rd_qp_idx, rd_br_idx;
  logic        rd_qp_val, rd_br_val;

  int checks = 0;
  int errors = 0;
  logic [63:0] ref_p;

  always #10 clk = ~clk;

  pred_cmp_wb u_dut (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic ref_rel(input logic sel, input logic [2:0] fn,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic na, input logic nb,
                                   input logic [5:0] pos);
    logic r;
    if (sel) r = a[pos];
    else begin
      case (fn)
        3'd0: r = (a == b);
        3'd1: r = (a != b);
        3'd2: r = ($signed(a) <  $signed(b));
        3'd3: r = ($signed(a) <= $signed(b));
        3'd4: r = ($signed(a) >  $signed(b));
        3'd5: r = ($signed(a) >= $signed(b));
        3'd6: r = (a <  b);
        default: r = (a >= b);
      endcase
    end
    if (na || nb) r = 1'b0;
    return r;
  endfunction

  task automatic do_op(input string tag, input logic [2:0] k, input logic sel,
                       input logic [2:0] fn, input logic [63:0] a,
                       input logic [63:0] b, input logic na, input logic nb,
                       input logic [5:0] pos, input logic [5:0] qp,
                       input logic [5:0] t1, input logic [5:0] t2);
    logic qv, r, e1, v1, e2, v2;
    @(negedge clk);
    op_valid = 1'b1; cmp_kind = k; rel_sel = sel; rel_fn = fn;
    src_a = a; src_b = b; nat_a = na; nat_b = nb; bit_pos = pos;
    qp_idx = qp; t1_idx = t1; t2_idx = t2; rd_qp_idx = t1; rd_br_idx = t2;
    #5;
    // R12: reads before the edge show the old contents
    check({"R12 old t1 ", tag}, rd_qp_val, ref_p[t1]);
    check({"R12 old t2 ", tag}, rd_br_val, ref_p[t2]);
    qv = ref_p[qp];
    r  = ref_rel(sel, fn, a, b, na, nb, pos);
    e1 = 0; e2 = 0; v1 = 0; v2 = 0;
    case (k)
      3'd0: begin e1 = qv; e2 = qv; v1 = r; v2 = !r; end
      3'd1: begin e1 = 1; e2 = 1; v1 = qv & r; v2 = qv & !r; end
      3'd2: begin e1 = qv & !r; e2 = e1; end
      3'd3: begin e1 = qv & r; e2 = e1; v1 = 1; v2 = 1; end
      3'd4: begin e1 = qv & r; e2 = e1; v1 = 1; v2 = 0; end
      default: ;
    endcase
    if (e2 && t2 != 0) ref_p[t2] = v2;
    if (e1 && t1 != 0) ref_p[t1] = v1;
    ref_p[0] = 1'b1;
    @(posedge clk);
    #1 op_valid = 1'b0;
    @(negedge clk);
    check({"t1 ", tag}, rd_qp_val, ref_p[t1]);
    check({"t2 ", tag}, rd_br_val, ref_p[t2]);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 0; cmp_kind = 0; rel_sel = 0; rel_fn = 0;
    src_a = 0; src_b = 0; nat_a = 0; nat_b = 0; bit_pos = 0;
    qp_idx = 0; t1_idx = 0; t2_idx = 0; rd_qp_idx = 0; rd_br_idx = 0;
    ref_p = 64'h1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset contents
    for (int i = 0; i < 64; i += 2) begin
      @(negedge clk);
      rd_qp_idx = 6'(i); rd_br_idx = 6'(i + 1);
      #1;
      check("R1 reset even", rd_qp_val, (i == 0));
      check("R1 reset odd", rd_br_val, 1'b0);
    end
    // R8: all relation codes on a pair whose orderings differ
    for (int f = 0; f < 8; f++)
      do_op("R8 relation", 3'd0, 0, 3'(f), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
            0, 0, 0, 6'd0, 6'd1, 6'd2);
    // R9: bit test
    do_op("R9 bit set", 3'd0, 1, 0, 64'h8000_0000_0000_0001, 0, 0, 0, 6'd63, 0, 6'd3, 6'd4);
    do_op("R9 bit clear", 3'd0, 1, 0, 64'h8000_0000_0000_0001, 0, 0, 0, 6'd5, 0, 6'd3, 6'd4);
    // R3: normal with a false qualifying predicate (entry 10 is 0)
    do_op("R3 qp false", 3'd0, 0, 3'd1, 5, 6, 0, 0, 0, 6'd10, 6'd3, 6'd4);
    do_op("R3 qp true", 3'd0, 0, 3'd0, 5, 5, 0, 0, 0, 6'd3, 6'd11, 6'd12);
    // R4: unconditional clears both when qp false, acts as plain compare on entry 0
    do_op("R4 qp false", 3'd1, 0, 3'd0, 5, 5, 0, 0, 0, 6'd10, 6'd3, 6'd4);
    do_op("R4 qp zero", 3'd1, 0, 3'd0, 5, 5, 0, 0, 0, 6'd0, 6'd3, 6'd4);
    // R6: or-type sets both; no write when relation false
    do_op("R6 set", 3'd3, 0, 3'd0, 7, 7, 0, 0, 0, 6'd0, 6'd13, 6'd14);
    do_op("R6 rel false", 3'd3, 0, 3'd0, 7, 8, 0, 0, 0, 6'd0, 6'd15, 6'd16);
    do_op("R6 qp false", 3'd3, 0, 3'd0, 7, 7, 0, 0, 0, 6'd10, 6'd15, 6'd16);
    // R5: and-type
    do_op("R5 rel true", 3'd2, 0, 3'd0, 7, 7, 0, 0, 0, 6'd0, 6'd13, 6'd14);
    do_op("R5 qp false", 3'd2, 0, 3'd0, 7, 8, 0, 0, 0, 6'd10, 6'd13, 6'd14);
    do_op("R5 clear", 3'd2, 0, 3'd0, 7, 8, 0, 0, 0, 6'd0, 6'd13, 6'd14);
    // R7: or-andcm, primed t1=0 t2=1
    do_op("R7 prime", 3'd0, 0, 3'd1, 7, 7, 0, 0, 0, 6'd0, 6'd20, 6'd21);
    do_op("R7 rel false", 3'd4, 0, 3'd0, 7, 8, 0, 0, 0, 6'd0, 6'd20, 6'd21);
    do_op("R7 rel true", 3'd4, 0, 3'd0, 7, 7, 0, 0, 0, 6'd0, 6'd20, 6'd21);
    // R10: deferred-exception flags
    do_op("R10 nat_a", 3'd0, 0, 3'd0, 9, 9, 1, 0, 0, 6'd0, 6'd22, 6'd23);
    do_op("R10 nat_b or", 3'd3, 0, 3'd0, 9, 9, 0, 1, 0, 6'd0, 6'd22, 6'd22);
    do_op("R10 nat bit", 3'd0, 1, 0, 64'hFF, 0, 1, 0, 6'd1, 6'd0, 6'd24, 6'd25);
    // R11: aliased targets
    do_op("R11 unc alias", 3'd1, 0, 3'd0, 1, 1, 0, 0, 0, 6'd0, 6'd7, 6'd7);
    do_op("R11 norm alias", 3'd0, 0, 3'd0, 1, 2, 0, 0, 0, 6'd0, 6'd7, 6'd7);
    // R2: writes to entry 0 are dropped
    do_op("R2 write p0", 3'd0, 0, 3'd0, 1, 2, 0, 0, 0, 6'd0, 6'd0, 6'd9);
    do_op("R2 unc p0", 3'd1, 0, 3'd0, 1, 2, 0, 0, 0, 6'd10, 6'd9, 6'd0);
    // R13: unused kind codes and idle cycles
    do_op("R13 kind5", 3'd5, 0, 3'd0, 1, 1, 0, 0, 0, 6'd0, 6'd11, 6'd12);
    do_op("R13 kind7", 3'd7, 0, 3'd1, 1, 1, 0, 0, 0, 6'd0, 6'd12, 6'd13);
    @(negedge clk);
    op_valid = 0; cmp_kind = 3'd3; qp_idx = 0; src_a = 0; src_b = 0; rel_fn = 0;
    t1_idx = 6'd30; t2_idx = 6'd31; rd_qp_idx = 6'd30; rd_br_idx = 6'd31;
    @(negedge clk);
    check("R13 idle t1", rd_qp_val, ref_p[30]);
    check("R13 idle t2", rd_br_val, ref_p[31]);
    // R3 R4 R5 R6 R7 mixed pseudo-random run
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      do_op("R3..R7 random", 3'($urandom), 1'($urandom), 3'($urandom), a, b,
            ($urandom % 8 == 0), ($urandom % 8 == 0), 6'($urandom),
            6'($urandom % 16), 6'($urandom % 16), 6'($urandom % 16));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule